// File: doc/BRIEF.md
# Skip-or-Fire Process Node with Bounded Queues

This block wraps a small Mealy machine so that it can run as one process in a network of non-blocking processes joined by tiny FIFOs. Each input and each output link of the node has its own queue. An upstream producer writes into an input queue after checking that queue's full flag. A downstream consumer reads from an output queue after checking that queue's valid flag. Neither side is ever stalled.

On every local trigger the node takes an all-or-nothing decision. It fires only when every input queue holds a token and every output queue has room. A firing pops one token from each input, evaluates the machine on those tokens and the current state, and pushes one result into each output queue. All of this happens in the trigger cycle. If any condition fails, the step is skipped and nothing inside the node changes.

Queue depth and initial contents depend on whether the link carries a unit delay. A unit-delay link gets two slots and starts with one preloaded token that holds the link's initial value. A plain link gets one slot and starts empty. With this sizing, a network built from such nodes keeps the synchronous semantics of the original machine graph.

Top module: `skipFireNode`

## Requirements
- R1: A trigger fires the node only when every input queue is non-empty and every output queue is non-full. A firing removes exactly one token from every input queue and adds exactly one token to every output queue.
- R2: On a firing, with input heads x0..x(N-1) and state s, the next state is (s + x0 + ... + x(N-1)) mod 256. The value pushed on output j is (next state + j) mod 256.
- R3: A trigger that does not meet the R1 condition raises `skipped` in that cycle. Such a trigger pops no input, pushes no output and leaves the state unchanged.
- R4: In a cycle without a trigger, `fired` and `skipped` are both low and the state does not change.
- R5: An input or output queue on a unit-delay link holds at most 2 tokens; a queue on a plain link holds at most 1. `inFull` shows when an input queue is at its limit, and a write into a full input queue is dropped.
- R6: After reset, the queue of each unit-delay link holds one token equal to its configured initial value. Each plain-link queue is empty, and the state equals its configured initial value.
- R7: Each output queue delivers its tokens in the order they were pushed, and `outValid` is high exactly when it is non-empty. A read request on an empty output queue is ignored.
- R8: `fired` and `skipped` are combinational in the trigger cycle, never both high, and exactly one is high whenever `trig` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local node clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Local trigger: attempt one step |
| inPush | input | NUM_IN | Per input link: producer writes a token |
| inData | input | NUM_IN*DW | Per input link: token value written |
| inFull | output | NUM_IN | Per input link: queue is at its depth limit |
| outPop | input | NUM_OUT | Per output link: consumer removes head token |
| outData | output | NUM_OUT*DW | Per output link: head token value |
| outValid | output | NUM_OUT | Per output link: queue holds a token |
| fired | output | 1 | The node fires in this cycle |
| skipped | output | 1 | The trigger in this cycle is skipped |

## Verification
A wrong token count in any queue shows up in the same cycle. Either `inFull` or `outValid` flips to the wrong value, or the next trigger takes the wrong fire-or-skip decision. A corrupted state register, or a token popped from the wrong slot, stays hidden until the next firing. It then appears as a wrong value at the head of an output queue one cycle after that firing. The sweep drives every combination of trigger, producer writes and consumer reads against a lock-step arithmetic model, so each such fault is caught within a few cycles of the firing that exposes it.

// File: rtl/procNodePkg.sv
package procNodePkg;
  // Strobes from the fire/skip control into the datapath.
  typedef struct packed {
    logic fire;
    logic skip;
  } nodeStrobes_t;
endpackage

// File: rtl/nodeQueue.sv
module nodeQueue #(
  parameter int          DW       = 8,
  parameter int          DEPTH    = 1,
  parameter bit          PRELOAD  = 1'b0,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] headData,
  output logic          notEmpty,
  output logic          notFull
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FILL0 = PRELOAD ? CW'(1) : CW'(0);

  logic [DEPTH-1:0][DW-1:0] slots;
  logic [CW-1:0] count;
  logic pushAcc, popAcc;
  logic [CW-1:0] wrIdx;

  assign notEmpty = (count != '0);
  assign notFull  = (count != CW'(DEPTH));
  assign pushAcc  = push && notFull;
  assign popAcc   = pop && notEmpty;
  assign wrIdx    = count - CW'(popAcc);
  assign headData = slots[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slots <= '0;
      if (PRELOAD) slots[0] <= INIT_VAL;
      count <= FILL0;
    end else begin
      if (popAcc) begin
        for (int k = 0; k < DEPTH - 1; k++) slots[k] <= slots[k+1];
      end
      if (pushAcc) slots[wrIdx] <= pushData;
      count <= count + CW'(pushAcc) - CW'(popAcc);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R5
  AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (popAcc && !pushAcc) |=> (count == $past(count) - CW'(1))); // R7
endmodule

// File: rtl/nodeCtrl.sv
module nodeCtrl
  import procNodePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trig,
  input  logic         inReady,
  input  logic         outRoom,
  output nodeStrobes_t strobes
);
  logic canStep;

  assign canStep      = inReady && outRoom;
  assign strobes.fire = trig && canStep;
  assign strobes.skip = trig && !canStep;

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.fire, strobes.skip})); // R8
  AST_TRIG_DECIDES: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> (strobes.fire || strobes.skip)); // R8
  AST_NO_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !trig |-> !(strobes.fire || strobes.skip)); // R4
endmodule

// File: rtl/nodeDatapath.sv
module nodeDatapath
  import procNodePkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2,
  parameter logic [NUM_IN-1:0]     IN_DELAY  = '0,
  parameter logic [NUM_OUT-1:0]    OUT_DELAY = '0,
  parameter logic [NUM_IN*DW-1:0]  IN_INIT   = '0,
  parameter logic [NUM_OUT*DW-1:0] OUT_INIT  = '0,
  parameter logic [DW-1:0]         INIT_STATE = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  nodeStrobes_t                 strobes,
  input  logic [NUM_IN-1:0]            inPush,
  input  logic [NUM_IN-1:0][DW-1:0]    inData,
  output logic [NUM_IN-1:0]            inFull,
  input  logic [NUM_OUT-1:0]           outPop,
  output logic [NUM_OUT-1:0][DW-1:0]   outData,
  output logic [NUM_OUT-1:0]           outValid,
  output logic                         inReady,
  output logic                         outRoom
);
  logic [NUM_IN-1:0][DW-1:0]  inHead;
  logic [NUM_IN-1:0]          inNotEmpty, inNotFull;
  logic [NUM_OUT-1:0]         outNotFull;
  logic [NUM_OUT-1:0][DW-1:0] outVal;
  logic [DW-1:0]              stateQ, nextState, tokenSum;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_inQ
    nodeQueue #(
      .DW(DW), .DEPTH(IN_DELAY[i] ? 2 : 1), .PRELOAD(IN_DELAY[i]),
      .INIT_VAL(IN_INIT[i*DW +: DW])
    ) q_i (
      .clk(clk), .rstN(rstN), .push(inPush[i]), .pushData(inData[i]),
      .pop(strobes.fire), .headData(inHead[i]),
      .notEmpty(inNotEmpty[i]), .notFull(inNotFull[i])
    );
    assign inFull[i] = !inNotFull[i];
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outQ
    nodeQueue #(
      .DW(DW), .DEPTH(OUT_DELAY[j] ? 2 : 1), .PRELOAD(OUT_DELAY[j]),
      .INIT_VAL(OUT_INIT[j*DW +: DW])
    ) q_o (
      .clk(clk), .rstN(rstN), .push(strobes.fire), .pushData(outVal[j]),
      .pop(outPop[j]), .headData(outData[j]),
      .notEmpty(outValid[j]), .notFull(outNotFull[j])
    );
  end

  assign inReady = &inNotEmpty;
  assign outRoom = &outNotFull;

  // Mealy step: state accumulates the input tokens; each output offsets it.
  always_comb begin
    tokenSum = '0;
    for (int i = 0; i < NUM_IN; i++) tokenSum = tokenSum + inHead[i];
    nextState = stateQ + tokenSum;
    for (int j = 0; j < NUM_OUT; j++) outVal[j] = nextState + DW'(j);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= INIT_STATE;
    else if (strobes.fire) stateQ <= nextState;
  end

  AST_FIRE_NEEDS_TOKENS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> (&inNotEmpty && &outNotFull)); // R1
  AST_SKIP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.skip |=> $stable(stateQ)); // R3
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fire |=> $stable(stateQ)); // R4
endmodule

// File: rtl/skipFireNode.sv
module skipFireNode
  import procNodePkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 2,
  parameter logic [NUM_IN-1:0]     IN_DELAY  = 2'b01,
  parameter logic [NUM_OUT-1:0]    OUT_DELAY = 2'b10,
  parameter logic [NUM_IN*DW-1:0]  IN_INIT   = {8'h00, 8'h05},
  parameter logic [NUM_OUT*DW-1:0] OUT_INIT  = {8'h0A, 8'h00},
  parameter logic [DW-1:0]         INIT_STATE = 8'h03
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       trig,
  input  logic [NUM_IN-1:0]          inPush,
  input  logic [NUM_IN-1:0][DW-1:0]  inData,
  output logic [NUM_IN-1:0]          inFull,
  input  logic [NUM_OUT-1:0]         outPop,
  output logic [NUM_OUT-1:0][DW-1:0] outData,
  output logic [NUM_OUT-1:0]         outValid,
  output logic                       fired,
  output logic                       skipped
);
  nodeStrobes_t strobes;
  logic inReady, outRoom;

  nodeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig),
    .inReady(inReady), .outRoom(outRoom), .strobes(strobes)
  );

  nodeDatapath #(
    .DW(DW), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
    .IN_DELAY(IN_DELAY), .OUT_DELAY(OUT_DELAY),
    .IN_INIT(IN_INIT), .OUT_INIT(OUT_INIT), .INIT_STATE(INIT_STATE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inPush(inPush), .inData(inData), .inFull(inFull),
    .outPop(outPop), .outData(outData), .outValid(outValid),
    .inReady(inReady), .outRoom(outRoom)
  );

  assign fired   = strobes.fire;
  assign skipped = strobes.skip;
endmodule

// File: tb/skipFireNode_tb_top.sv
module skipFireNode_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic trig;
  logic [1:0] inPush, outPop;
  logic [1:0][DW-1:0] inData;
  logic [1:0] inFull, outValid;
  logic [1:0][DW-1:0] outData;
  logic fired, skipped;

  always #10 clk = ~clk; // 50 MHz

  skipFireNode dut_i (
    .clk(clk), .rstN(rstN), .trig(trig), .inPush(inPush), .inData(inData),
    .inFull(inFull), .outPop(outPop), .outData(outData), .outValid(outValid),
    .fired(fired), .skipped(skipped)
  );

  // Model of the default configuration: input 0 and output 1 are unit-delay links.
  int inDep[2]  = '{2, 1};
  int outDep[2] = '{1, 2};
  int inQ[2][2], outQ[2][2];
  int inCnt[2], outCnt[2];
  int st;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkQueues();
    for (int i = 0; i < 2; i++)
      chk("R5 inFull", int'(inFull[i]), int'(inCnt[i] == inDep[i]));
    for (int j = 0; j < 2; j++) begin
      chk("R7 outValid", int'(outValid[j]), int'(outCnt[j] > 0));
      if (outCnt[j] > 0) chk("R2 output head value", int'(outData[j]), outQ[j][0]);
    end
  endtask

  initial begin
    trig = 0; inPush = 0; outPop = 0; inData = '0; rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    inQ = '{'{5, 0}, '{0, 0}}; inCnt = '{1, 0};
    outQ = '{'{0, 0}, '{8'h0A, 0}}; outCnt = '{0, 1};
    st = 3;
    @(negedge clk);
    chk("R6 unit-delay input not full", int'(inFull[0]), 0);
    chk("R6 plain output empty", int'(outValid[0]), 0);
    chk("R6 unit-delay output preloaded", int'(outValid[1]), 1);
    chk("R6 preload value", int'(outData[1]), 8'h0A);
    for (int pass = 0; pass < 6; pass++) begin
      for (int v = 0; v < 32; v++) begin
        logic [4:0] vv;
        bit expFire, canStep;
        int sum;
        logic [1:0] pushS, popS;
        logic [1:0][DW-1:0] dataS;
        bit trigS;
        vv = pass[0] ? ~5'(v) : 5'(v);
        if (pass >= 2) vv = 5'(v * 7 + pass);
        @(negedge clk);
        trig = vv[0]; inPush = vv[2:1]; outPop = vv[4:3];
        for (int i = 0; i < 2; i++) inData[i] = DW'(pass * 97 + v * 13 + i * 29);
        #2;
        canStep = inCnt[0] > 0 && inCnt[1] > 0 && outCnt[0] < outDep[0] && outCnt[1] < outDep[1];
        expFire = trig && canStep;
        if (trig) begin
          chk("R1 fire decision", int'(fired), int'(expFire));
          chk("R3 skip decision", int'(skipped), int'(!canStep));
        end else begin
          chk("R4 no fire without trigger", int'(fired), 0);
          chk("R4 no skip without trigger", int'(skipped), 0);
        end
        checkQueues();
        trigS = trig; pushS = inPush; popS = outPop; dataS = inData;
        sum = (st + inQ[0][0] + inQ[1][0]) & 255;
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
          bit pushA;
          pushA = pushS[i] && inCnt[i] < inDep[i];
          if (expFire) begin inQ[i][0] = inQ[i][1]; inCnt[i]--; end
          if (pushA) begin inQ[i][inCnt[i]] = int'(dataS[i]); inCnt[i]++; end
        end
        for (int j = 0; j < 2; j++) begin
          bit popA;
          popA = popS[j] && outCnt[j] > 0;
          if (popA) begin outQ[j][0] = outQ[j][1]; outCnt[j]--; end
          if (expFire) begin outQ[j][outCnt[j]] = (sum + j) & 255; outCnt[j]++; end
        end
        if (expFire) st = sum;
        if (trigS && !expFire) chk("R3 skipped step leaves queues", int'(outValid[0]), int'(outCnt[0] > 0));
      end
    end
    trig = 0; inPush = 0; outPop = 0;
    @(negedge clk);
    checkQueues();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule